// File: doc/BRIEF.md
# Byte-Aligned Two-Stage Serial Shifter

This block turns bytes written by a host processor into a serial bit stream for one test-access signal line, for example a mode-select or data-out line. Bytes go into a two-entry storage queue. On every cycle where the scan clock strobe is active and the shifter is enabled, one bit of the oldest stored byte is presented on the serial output. The bits go out least significant first.

The shifter keeps no bit counter of its own. A 3-bit position count that is shared by every shifter in the controller selects which bit goes out. The same count decides when a byte is used up, which happens at position 7. Because of this, all streams stay byte-aligned. A shifter that is enabled partway through a byte sends only the bits from the current position up to bit 7 before it moves to the next byte. The host watches a not-full flag to know when another byte can be written.

Top module: `bytealign_shifter`

## Requirements
- R1: While `rst` is high, and on the cycle after `soft_rst` is high, `ser_out` is 0, `not_full` is 1 and the queue is empty. A following shift does not change `ser_out`.
- R2: `not_full` is a registered flag. It is 1 when fewer than two bytes are stored and 0 when two are stored. It changes on the clock edge that accepts a write or retires a byte.
- R3: A write while `not_full` is 0 is ignored. The two stored bytes are later sent unchanged.
- R4: On a cycle where `tck_en` and `shift_en` are both 1 and a byte is stored, `ser_out` after that edge equals bit number `bit_pos` of the oldest byte. With `bit_pos` stepping 0 to 7, the byte leaves least significant bit first.
- R5: A shift at `bit_pos` = 7 retires the oldest byte. The next stored byte supplies the bits from the following position 0 onward.
- R6: If the shifter is enabled with a byte stored while `bit_pos` = k, only bits k through 7 of that byte are sent (8−k bits, so five bits for k = 3) before the byte is retired.
- R7: A shift with the queue empty leaves `ser_out` at its last value.
- R8: With `tck_en` or `shift_en` at 0, `ser_out` and the stored bytes do not change, even while `bit_pos` moves.
- R9: A write and a retirement may fall on the same edge. When the queue is not full, both take effect and the fill level is unchanged. When it is full, the write is ignored and only the retirement takes effect.
- R10: `soft_rst` takes priority over a write or a shift on the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous clear of queue and output |
| wr_en | input | 1 | Host write strobe |
| wr_data | input | BYTE_W | Byte to store |
| tck_en | input | 1 | Scan clock strobe, one per scan bit |
| shift_en | input | 1 | Enables this shifter |
| bit_pos | input | PW | Shared bit position count |
| ser_out | output | 1 | Registered serial bit |
| not_full | output | 1 | Registered flag: room for a byte |

## Verification
The collision of interest is a host write landing on the same edge as the retirement of a byte at position 7. The bench drives the queue to one entry and to two entries, then writes exactly on the position-7 shift. It judges the outcome from `not_full` and from the bytes that later come out of `ser_out`. The random phase makes the same collision happen many times. A reference model decides acceptance only from the fill level before the edge.

// File: rtl/sft_pkg.sv
package sft_pkg;
  // One request to the byte queue per cycle; clear beats push and pop.
  typedef struct packed {
    logic clear;
    logic push;
    logic pop;
  } fifo_op_t;
endpackage

// File: rtl/sft_fifo.sv
module sft_fifo
  import sft_pkg::*;
#(
  parameter int W     = 8,
  parameter int DEPTH = 2,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  fifo_op_t      op,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  head,
  output logic [CW-1:0] fill,
  output logic          has_room
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;
  logic [CW-1:0] fill_n;

  assign do_push = op.push && has_room;
  assign do_pop  = op.pop && (fill != '0);

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    fill_n = fill;
    if (do_push && !do_pop) fill_n = fill + 1'b1;
    else if (do_pop && !do_push) fill_n = fill - 1'b1;
  end

  // storage without reset so it may map to RAM
  always_ff @(posedge clk) begin
    if (do_push && !op.clear) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst || op.clear) begin
      wptr     <= '0;
      rptr     <= '0;
      fill     <= '0;
      has_room <= 1'b1;
    end else begin
      if (do_push) wptr <= bump(wptr);
      if (do_pop)  rptr <= bump(rptr);
      fill     <= fill_n;
      has_room <= (fill_n < CW'(DEPTH));
    end
  end

  assign head = mem[rptr];
endmodule

// File: rtl/sft_tap.sv
module sft_tap #(
  parameter int W   = 8,
  localparam int PW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          fire,
  input  logic [W-1:0]  byte_in,
  input  logic [PW-1:0] pos,
  output logic          ser
);
  always_ff @(posedge clk) begin
    if (rst || clear) ser <= 1'b0;
    else if (fire)    ser <= byte_in[pos];
  end
endmodule

// File: rtl/bytealign_shifter.sv
module bytealign_shifter
  import sft_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 2,
  localparam int PW    = $clog2(BYTE_W),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              tck_en,
  input  logic              shift_en,
  input  logic [PW-1:0]     bit_pos,
  output logic              ser_out,
  output logic              not_full
);
  fifo_op_t          op;
  logic [BYTE_W-1:0] head;
  logic [CW-1:0]     fill_cnt;
  logic              step, last_pos;

  assign step     = tck_en && shift_en;
  assign last_pos = (bit_pos == PW'(BYTE_W - 1));

  always_comb begin
    op.clear = soft_rst;
    op.push  = wr_en && !soft_rst;
    op.pop   = step && last_pos && !soft_rst;
  end

  sft_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst(rst), .op(op), .wdata(wr_data),
    .head(head), .fill(fill_cnt), .has_room(not_full)
  );

  sft_tap #(.W(BYTE_W)) u_tap (
    .clk(clk), .rst(rst), .clear(soft_rst),
    .fire(step && (fill_cnt != '0)),
    .byte_in(head), .pos(bit_pos), .ser(ser_out)
  );
endmodule

// File: rtl/bytealign_shifter_chk.sv
module bytealign_shifter_chk #(
  parameter int BYTE_W = 8,
  parameter int DEPTH  = 2,
  localparam int PW    = $clog2(BYTE_W),
  localparam int CW    = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          soft_rst,
  input logic          wr_en,
  input logic          tck_en,
  input logic          shift_en,
  input logic [PW-1:0] bit_pos,
  input logic          ser_out,
  input logic          not_full,
  input logic [CW-1:0] fill_cnt
);
  a_r1_reset_state: assert property (@(posedge clk)
    (rst || soft_rst) |=> (!ser_out && not_full && fill_cnt == '0));

  a_r2_flag_level: assert property (@(posedge clk) disable iff (rst)
    $past(!rst) |-> (not_full == (fill_cnt < CW'(DEPTH))));

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (!not_full && !soft_rst && !(tck_en && shift_en && bit_pos == PW'(BYTE_W - 1)))
      |=> (!not_full && $stable(fill_cnt)));

  a_r7_empty_hold: assert property (@(posedge clk) disable iff (rst)
    (fill_cnt == '0 && !soft_rst) |=> $stable(ser_out));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!(tck_en && shift_en) && !soft_rst && !wr_en) |=> ($stable(ser_out) && $stable(fill_cnt)));
endmodule

bind bytealign_shifter bytealign_shifter_chk #(.BYTE_W(BYTE_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .soft_rst(soft_rst), .wr_en(wr_en), .tck_en(tck_en),
  .shift_en(shift_en), .bit_pos(bit_pos), .ser_out(ser_out), .not_full(not_full),
  .fill_cnt(fill_cnt)
);

// File: tb/sim_bytealign_shifter.sv
module sim_bytealign_shifter;
  logic       clk = 1'b0;
  logic       rst, soft_rst, wr_en, tck_en, shift_en;
  logic [7:0] wr_data;
  logic [2:0] bit_pos;
  logic       ser_out, not_full;

  int checks = 0, fails = 0, cycles = 0;
  logic [7:0] mq [2];
  int         mcnt;
  logic       mser;
  logic [7:0] grab;
  int         ngrab;

  always #2 clk = ~clk;

  bytealign_shifter u0 (
    .clk(clk), .rst(rst), .soft_rst(soft_rst), .wr_en(wr_en), .wr_data(wr_data),
    .tck_en(tck_en), .shift_en(shift_en), .bit_pos(bit_pos),
    .ser_out(ser_out), .not_full(not_full)
  );

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected <150000", cycles);
      finish_run();
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
    end
  endtask

  // reference model step, computed from the requirements
  function automatic void model(input logic r, input logic sr, input logic w, input logic [7:0] d,
                                input logic t, input logic e, input logic [2:0] p);
    logic pop, push;
    if (r || sr) begin
      mcnt = 0; mser = 1'b0; return;
    end
    push = w && (mcnt < 2);
    pop  = t && e && (p == 3'd7) && (mcnt > 0);
    if (t && e && mcnt > 0) mser = mq[0][p];
    if (pop) begin mq[0] = mq[1]; mcnt--; end
    if (push) begin mq[mcnt] = d; mcnt++; end
  endfunction

  // one clock: drive at negedge, check at next negedge
  task automatic cyc(input string tag, input logic w, input logic [7:0] d, input logic t,
                     input logic e, input logic sr);
    wr_en = w; wr_data = d; tck_en = t; shift_en = e; soft_rst = sr;
    model(rst, sr, w, d, t, e, bit_pos);
    @(posedge clk);
    @(negedge clk);
    if (t) bit_pos = bit_pos + 3'd1;
    chk(tag, ser_out, mser, "ser_out");
    chk(tag, not_full, (mcnt < 2), "not_full");
    if (t && e) begin grab[ngrab[2:0]] = ser_out; ngrab++; end
  endtask

  initial begin
    rst = 1'b1; soft_rst = 0; wr_en = 0; tck_en = 0; shift_en = 0; wr_data = 0; bit_pos = 0;
    mcnt = 0; mser = 0; ngrab = 0; grab = 0;
    @(negedge clk); @(negedge clk);
    cyc("R1", 0, 8'h00, 0, 0, 0);
    chk("R1", ser_out, 1'b0, "ser_out in reset");
    chk("R1", not_full, 1'b1, "not_full in reset");
    rst = 1'b0;
    cyc("R1", 0, 8'h00, 1, 1, 0);       // shift on empty queue after reset
    chk("R1", ser_out, 1'b0, "ser_out after empty shift");
    while (bit_pos != 0) cyc("R8", 0, 0, 1, 0, 0);

    // R2 / R3 fill and overflow
    cyc("R2", 1, 8'hA5, 0, 0, 0);
    chk("R2", not_full, 1'b1, "one byte stored");
    cyc("R2", 1, 8'h3C, 0, 0, 0);
    chk("R2", not_full, 1'b0, "two bytes stored");
    cyc("R3", 1, 8'hFF, 0, 0, 0);
    chk("R3", not_full, 1'b0, "write while full");

    // R4 LSB first, R5 next byte
    ngrab = 0;
    for (int i = 0; i < 8; i++) cyc("R4", 0, 0, 1, 1, 0);
    checks++; if (grab !== 8'hA5) begin fails++; $display("FAIL R4 byte: actual=%h expected=a5", grab); end
    chk("R5", not_full, 1'b1, "room after retire");
    ngrab = 0;
    for (int i = 0; i < 8; i++) cyc("R5", 0, 0, 1, 1, 0);
    checks++; if (grab !== 8'h3C) begin fails++; $display("FAIL R3 data intact: actual=%h expected=3c", grab); end

    // R7 empty hold
    for (int i = 0; i < 4; i++) cyc("R7", 0, 0, 1, 1, 0);
    chk("R7", ser_out, 1'b0, "held last bit");

    // R8 idle: byte stored, strobe or enable off
    cyc("R8", 1, 8'hFF, 0, 0, 0);
    for (int i = 0; i < 3; i++) cyc("R8", 0, 0, 0, 1, 0);
    for (int i = 0; i < 3; i++) cyc("R8", 0, 0, 1, 0, 0);
    chk("R8", ser_out, 1'b0, "no shift while idle");

    // R6: byte FF stored, enable at position 3
    while (bit_pos != 3) cyc("R8", 0, 0, 1, 0, 0);
    cyc("R6", 1, 8'h00, 0, 0, 0);       // queue full: FF then 00
    ngrab = 0;
    for (int i = 0; i < 5; i++) cyc("R6", 0, 0, 1, 1, 0);
    checks++; if (ngrab != 5 || grab[4:0] !== 5'b11111) begin
      fails++; $display("FAIL R6 partial: actual=%0d bits %b expected=5 bits 11111", ngrab, grab[4:0]);
    end
    chk("R6", not_full, 1'b1, "retired after five bits");
    cyc("R6", 0, 0, 1, 1, 0);
    chk("R6", ser_out, 1'b0, "next byte from position 0");

    // R9 collision: one stored (00 partly sent), write on position 7
    while (bit_pos != 7) cyc("R9", 0, 0, 1, 1, 0);
    cyc("R9", 1, 8'h81, 1, 1, 0);
    chk("R9", not_full, 1'b1, "fill unchanged at one");
    cyc("R9", 1, 8'h7E, 0, 0, 0);       // now full
    while (bit_pos != 7) cyc("R9", 0, 0, 1, 1, 0);
    cyc("R9", 1, 8'h55, 1, 1, 0);       // full: write ignored, retire
    chk("R9", not_full, 1'b1, "write ignored while full");
    ngrab = 0;
    for (int i = 0; i < 8; i++) cyc("R9", 0, 0, 1, 1, 0);
    checks++; if (grab !== 8'h7E) begin fails++; $display("FAIL R9 data: actual=%h expected=7e", grab); end

    // R10 soft reset with write and shift
    cyc("R10", 1, 8'hFF, 0, 0, 0);
    cyc("R10", 1, 8'hFF, 1, 1, 1);
    chk("R10", not_full, 1'b1, "queue cleared");
    chk("R10", ser_out, 1'b0, "output cleared");
    for (int i = 0; i < 8; i++) cyc("R10", 0, 0, 1, 1, 0);
    chk("R1", ser_out, 1'b0, "nothing left after soft reset");

    // constrained random
    void'($urandom(32'd1234));
    for (int i = 0; i < 4000; i++) begin
      logic w, t, e, s;
      w = ($urandom % 3) == 0;
      t = ($urandom % 4) != 0;
      e = (i % 40) < 30;
      s = ($urandom % 200) == 0;
      cyc("R4", w, 8'($urandom), t, e, s);
    end
    finish_run();
  end
endmodule